// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is a small shared-memory multiprocessor memory subsystem. Each processor port has its own cache controller. Every controller keeps a sharing state for each of its lines, and all controllers share one bus. A round-robin arbiter hands the bus to one controller at a time. Every other controller watches each transaction on that bus. A controller that holds a dirty copy of the requested block writes it back to memory. A controller that holds a copy the requester is about to own drops that copy. Memory is a fixed-latency model behind the bus.

Each cache line is Invalid, Shared or Modified. Loads that miss place a read request on the bus. Stores to a line that is not Modified place an exclusive (invalidating) request on the bus. Modified lines are written back when they are snooped or evicted. A processor sees a stall from the cycle after its request until its operation completes, including any bus transaction and the snoop responses to it. Writes to one block are ordered by the arbiter's grant order.

Top module: `snoop_mp_system`

## Requirements
- R1: After reset, every line is Invalid, no processor is stalled and no completion is signalled. Memory word at address a holds (3*a + 1) mod 2^DW.
- R2: A load to a block held Shared or Modified completes on the second rising edge after the request is sampled and returns the cached value.
- R3: A load miss returns the most recently stored value of the block from any processor (or the initial memory value if none). It then leaves the line Shared.
- R4: When a store to a block is granted the bus, every other cache holding that block in Modified first writes it back to memory and then invalidates it.
- R5: A Modified line that snoops another processor's read request writes its data back and becomes Shared. A later store to it by its holder must go through the bus again, taking more than two cycles.
- R6: A store to a line already Modified completes in two cycles without using the bus.
- R7: A store to a Shared or Invalid line issues an exclusive request. Afterwards, a load of that block by any other processor is a miss that returns the new value.
- R8: A Modified line displaced by a different block at the same index is written back before the refill. Another processor then reads the displaced value.
- R9: Requests pending at the same time are granted in round-robin order, starting from processor 0 after reset. Concurrent stores to one block therefore complete in processor order 0, 1, 2, and all processors then read processor 2's value.
- R10: At most one bus grant is active per cycle, and a grant goes only to a controller that requested in the previous cycle.
- R11: No block is Modified in one cache while any other cache holds a valid copy. A Shared line always equals memory.
- R12: Stall is high from the cycle after a request until completion. Completion is a single-cycle pulse that follows a stalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | NCPU | Per-processor request strobe, sampled while idle |
| cpu_we | input | NCPU | 1 = store, 0 = load |
| cpu_addr | input | NCPU*AW | Per-processor word address |
| cpu_wdata | input | NCPU*DW | Per-processor store data |
| cpu_rdata | output | NCPU*DW | Load result, valid with cpu_done |
| cpu_done | output | NCPU | One-cycle completion pulse |
| cpu_stall | output | NCPU | Operation in progress |

## Verification
The assertions assume a processor raises cpu_req only while its stall is low and drops it before completion. They also assume that addresses and data are held stable during the request cycle. The bench holds each request for exactly one sampled edge. It waits for the completion pulse before issuing that processor's next operation. Concurrent traffic comes only from requests issued on the same edge, so every overlap the invariants see is a legal one.

// File: rtl/snoop_pkg.sv
// Shared types for the snooping coherence subsystem.
// Assumes: line states and bus commands fit in two bits.
package snoop_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_NOP = 2'd0,
        BUS_RD  = 2'd1,
        BUS_RDX = 2'd2,
        BUS_WB  = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        C_IDLE  = 3'd0,
        C_CHECK = 3'd1,
        C_WB    = 3'd2,
        C_MISS  = 3'd3,
        C_WAIT  = 3'd4
    } ctl_st_t;
endpackage

// File: rtl/snoop_rr_arbiter.sv
// Round-robin bus arbiter. One owner holds the bus from its grant
// pulse until it raises release. Assumes release only comes from the owner.
module snoop_rr_arbiter #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  rel,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] owner,
    output logic          busy
);
    logic [IW-1:0] last_q;
    logic [IW-1:0] pick;
    logic          found;

    // Pick the first requester after the previous winner.
    always_comb begin
        found = 1'b0;
        pick  = last_q;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end

    // Track ownership and emit a one-cycle grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            owner  <= '0;
            gnt    <= '0;
            last_q <= IW'(N - 1);
        end else begin
            gnt <= '0;
            if (busy) begin
                if (rel[owner]) busy <= 1'b0;
            end else if (found) begin
                busy      <= 1'b1;
                owner     <= pick;
                last_q    <= pick;
                gnt[pick] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/snoop_mem_model.sv
// Main memory: one write port, one combinational read port.
// Reset loads word a with (3*a+1). Read latency is modelled by the requester.
module snoop_mem_model #(
    parameter int AW = 6,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [DEPTH*DW-1:0] image
);
    logic [DW-1:0] mem_q [DEPTH];

    // Initialise on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(3 * i + 1);
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // Read port shares the bus address.
    assign rdata = mem_q[addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_img
        assign image[g*DW +: DW] = mem_q[g];
    end
endmodule

// File: rtl/snoop_cache_ctrl.sv
// Per-processor direct-mapped cache with Invalid/Shared/Modified states.
// Serves processor loads and stores, issues bus requests and snoops the others.
// Assumes one-word blocks, an atomic bus held by one owner, and a snoop
// presented in the single grant cycle of each transaction.
module snoop_cache_ctrl import snoop_pkg::*; #(
    parameter int AW  = 6,
    parameter int DW  = 8,
    parameter int NL  = 4,
    parameter int LAT = 3,
    localparam int IXW  = $clog2(NL),
    localparam int TW   = AW - IXW,
    localparam int CNTW = $clog2(LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic             cpu_done,
    output logic             cpu_stall,
    output logic             bus_req,
    output logic             bus_rel,
    input  logic             bus_gnt,
    output bus_cmd_t         req_cmd,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_data,
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [AW-1:0]    snp_addr,
    output logic             flush_en,
    output logic [DW-1:0]    flush_data,
    input  logic [DW-1:0]    mem_rdata,
    output logic [NL*2-1:0]  dbg_st,
    output logic [NL*TW-1:0] dbg_tag,
    output logic [NL*DW-1:0] dbg_data
);
    line_st_t        st_q  [NL];
    logic [TW-1:0]   tag_q [NL];
    logic [DW-1:0]   dat_q [NL];

    ctl_st_t         state;
    logic            o_we;
    logic [AW-1:0]   o_addr;
    logic [DW-1:0]   o_wdata;
    logic [TW-1:0]   vtag_q;
    logic [CNTW-1:0] cnt_q;

    logic [IXW-1:0]  o_idx, s_idx;
    logic [TW-1:0]   o_tag, s_tag;
    logic            tag_hit, s_hit, snp_hold, wb_live;

    assign o_idx = o_addr[IXW-1:0];
    assign o_tag = o_addr[AW-1:IXW];
    assign s_idx = snp_addr[IXW-1:0];
    assign s_tag = snp_addr[AW-1:IXW];

    // Local lookup of the captured operation.
    assign tag_hit  = (st_q[o_idx] != LN_INV) && (tag_q[o_idx] == o_tag);
    assign snp_hold = snp_valid && (s_idx == o_idx);

    // Snoop lookup: a data request hits a valid copy of the same block.
    assign s_hit = snp_valid && (snp_cmd == BUS_RD || snp_cmd == BUS_RDX)
                   && (st_q[s_idx] != LN_INV) && (tag_q[s_idx] == s_tag);
    assign flush_en   = s_hit && (st_q[s_idx] == LN_MOD);
    assign flush_data = dat_q[s_idx];

    // Victim still dirty and still ours when the write-back is granted.
    assign wb_live = (st_q[o_idx] == LN_MOD) && (tag_q[o_idx] == vtag_q);

    // Bus request fields for the current phase.
    always_comb begin
        req_cmd  = BUS_NOP;
        req_addr = o_addr;
        req_data = dat_q[o_idx];
        if (state == C_WB) begin
            req_cmd  = wb_live ? BUS_WB : BUS_NOP;
            req_addr = {vtag_q, o_idx};
        end else if (state == C_MISS || state == C_WAIT) begin
            req_cmd = o_we ? BUS_RDX : BUS_RD;
        end
    end

    assign bus_req   = (state == C_WB) || (state == C_MISS);
    assign bus_rel   = ((state == C_WB) && bus_gnt) || ((state == C_WAIT) && (cnt_q == '0));
    assign cpu_stall = (state != C_IDLE);

    // Controller sequencing together with line-state updates from snoops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= C_IDLE;
            o_we      <= 1'b0;
            o_addr    <= '0;
            o_wdata   <= '0;
            vtag_q    <= '0;
            cnt_q     <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            for (int l = 0; l < NL; l++) begin
                st_q[l]  <= LN_INV;
                tag_q[l] <= '0;
                dat_q[l] <= '0;
            end
        end else begin
            cpu_done <= 1'b0;
            if (s_hit) begin
                if (snp_cmd == BUS_RDX)          st_q[s_idx] <= LN_INV;
                else if (st_q[s_idx] == LN_MOD)  st_q[s_idx] <= LN_SHR;
            end
            case (state)
                C_IDLE: begin
                    if (cpu_req) begin
                        o_we    <= cpu_we;
                        o_addr  <= cpu_addr;
                        o_wdata <= cpu_wdata;
                        state   <= C_CHECK;
                    end
                end
                C_CHECK: begin
                    if (snp_hold) begin
                        state <= C_CHECK;
                    end else if (tag_hit && (!o_we || st_q[o_idx] == LN_MOD)) begin
                        if (o_we) dat_q[o_idx] <= o_wdata;
                        else      cpu_rdata    <= dat_q[o_idx];
                        cpu_done <= 1'b1;
                        state    <= C_IDLE;
                    end else if (st_q[o_idx] == LN_MOD) begin
                        vtag_q <= tag_q[o_idx];
                        state  <= C_WB;
                    end else begin
                        state <= C_MISS;
                    end
                end
                C_WB: begin
                    if (bus_gnt) begin
                        st_q[o_idx] <= LN_INV;
                        state       <= C_MISS;
                    end
                end
                C_MISS: begin
                    if (bus_gnt) begin
                        cnt_q <= CNTW'(LAT - 1);
                        state <= C_WAIT;
                    end
                end
                C_WAIT: begin
                    if (cnt_q == '0) begin
                        tag_q[o_idx] <= o_tag;
                        st_q[o_idx]  <= o_we ? LN_MOD : LN_SHR;
                        dat_q[o_idx] <= o_we ? o_wdata : mem_rdata;
                        cpu_rdata    <= mem_rdata;
                        cpu_done     <= 1'b1;
                        state        <= C_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_dbg
        assign dbg_st[g*2 +: 2]     = st_q[g];
        assign dbg_tag[g*TW +: TW]  = tag_q[g];
        assign dbg_data[g*DW +: DW] = dat_q[g];
    end
endmodule

// File: rtl/snoop_mp_system.sv
// Top: NCPU cache controllers, the arbiter, the bus multiplexer and memory.
// Assumes at most one memory writer per cycle (one dirty owner per block).
module snoop_mp_system import snoop_pkg::*; #(
    parameter int NCPU = 3,
    parameter int AW   = 6,
    parameter int DW   = 8,
    parameter int NL   = 4,
    parameter int LAT  = 3,
    localparam int IXW   = $clog2(NL),
    localparam int TW    = AW - IXW,
    localparam int OW    = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCPU-1:0]      cpu_req,
    input  logic [NCPU-1:0]      cpu_we,
    input  logic [NCPU*AW-1:0]   cpu_addr,
    input  logic [NCPU*DW-1:0]   cpu_wdata,
    output logic [NCPU*DW-1:0]   cpu_rdata,
    output logic [NCPU-1:0]      cpu_done,
    output logic [NCPU-1:0]      cpu_stall
);
    logic [NCPU-1:0]       ctl_bus_req, ctl_rel, arb_gnt, flush_en_v;
    bus_cmd_t              rq_cmd  [NCPU];
    logic [AW-1:0]         rq_addr [NCPU];
    logic [DW-1:0]         rq_data [NCPU];
    logic [DW-1:0]         fl_data [NCPU];
    logic [OW-1:0]         owner;
    logic                  arb_busy;
    logic                  bus_valid, bus_wb, mem_we;
    bus_cmd_t              bus_cmd;
    logic [AW-1:0]         bus_addr;
    logic [DW-1:0]         bus_data, mem_wdata, mem_rdata;
    logic [DEPTH*DW-1:0]   mem_image;
    logic [NCPU*NL*2-1:0]  dbg_st_all;
    logic [NCPU*NL*TW-1:0] dbg_tag_all;
    logic [NCPU*NL*DW-1:0] dbg_data_all;

    snoop_rr_arbiter #(.N(NCPU)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(ctl_bus_req), .rel(ctl_rel),
        .gnt(arb_gnt), .owner(owner), .busy(arb_busy)
    );

    // Owner's request drives the shared bus.
    assign bus_valid = |arb_gnt;
    assign bus_cmd   = rq_cmd[owner];
    assign bus_addr  = rq_addr[owner];
    assign bus_data  = rq_data[owner];
    assign bus_wb    = bus_valid && (bus_cmd == BUS_WB);

    // Merge snoop flush data with victim write-back data.
    always_comb begin
        mem_wdata = bus_wb ? bus_data : '0;
        for (int i = 0; i < NCPU; i++) begin
            if (flush_en_v[i]) mem_wdata = mem_wdata | fl_data[i];
        end
    end
    assign mem_we = bus_wb || (|flush_en_v);

    snoop_mem_model #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(bus_addr),
        .wdata(mem_wdata), .rdata(mem_rdata), .image(mem_image)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        logic snp_v;
        assign snp_v = bus_valid && (owner != OW'(g));
        snoop_cache_ctrl #(.AW(AW), .DW(DW), .NL(NL), .LAT(LAT)) u_ctl (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]),
            .cpu_addr(cpu_addr[g*AW +: AW]), .cpu_wdata(cpu_wdata[g*DW +: DW]),
            .cpu_rdata(cpu_rdata[g*DW +: DW]), .cpu_done(cpu_done[g]),
            .cpu_stall(cpu_stall[g]),
            .bus_req(ctl_bus_req[g]), .bus_rel(ctl_rel[g]), .bus_gnt(arb_gnt[g]),
            .req_cmd(rq_cmd[g]), .req_addr(rq_addr[g]), .req_data(rq_data[g]),
            .snp_valid(snp_v), .snp_cmd(bus_cmd), .snp_addr(bus_addr),
            .flush_en(flush_en_v[g]), .flush_data(fl_data[g]),
            .mem_rdata(mem_rdata),
            .dbg_st(dbg_st_all[g*NL*2 +: NL*2]),
            .dbg_tag(dbg_tag_all[g*NL*TW +: NL*TW]),
            .dbg_data(dbg_data_all[g*NL*DW +: NL*DW])
        );
    end
endmodule

// File: rtl/snoop_mp_checker.sv
// Protocol invariants for snoop_mp_system, attached by bind.
// Assumes processors follow the request rules stated in the brief.
module snoop_mp_checker #(
    parameter int NCPU = 3,
    parameter int AW   = 6,
    parameter int DW   = 8,
    parameter int NL   = 4,
    localparam int IXW   = $clog2(NL),
    localparam int TW    = AW - IXW,
    localparam int DEPTH = 1 << AW
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCPU-1:0]      arb_gnt,
    input logic [NCPU-1:0]      ctl_bus_req,
    input logic [NCPU-1:0]      flush_en_v,
    input logic                 bus_wb,
    input logic [NCPU-1:0]      cpu_done,
    input logic [NCPU-1:0]      cpu_stall,
    input logic [NCPU*NL*2-1:0] dbg_st_all,
    input logic [NCPU*NL*TW-1:0] dbg_tag_all,
    input logic [NCPU*NL*DW-1:0] dbg_data_all,
    input logic [DEPTH*DW-1:0]  mem_image
);
    logic owner_bad, shared_bad;

    // Scan all caches for conflicting owners and stale shared lines.
    always_comb begin
        owner_bad  = 1'b0;
        shared_bad = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            for (int l = 0; l < NL; l++) begin
                logic [1:0]    si;
                logic [TW-1:0] ti;
                int            a;
                si = dbg_st_all[(i*NL + l)*2 +: 2];
                ti = dbg_tag_all[(i*NL + l)*TW +: TW];
                a  = int'(ti) * NL + l;
                if (si == 2'd1 && dbg_data_all[(i*NL + l)*DW +: DW] != mem_image[a*DW +: DW])
                    shared_bad = 1'b1;
                if (si == 2'd2) begin
                    for (int j = 0; j < NCPU; j++) begin
                        if (j != i && dbg_st_all[(j*NL + l)*2 +: 2] != 2'd0
                            && dbg_tag_all[(j*NL + l)*TW +: TW] == ti)
                            owner_bad = 1'b1;
                    end
                end
            end
        end
    end

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_gnt));

    assert_single_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_bad);

    assert_shared_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_bad);

    assert_one_mem_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flush_en_v, bus_wb}) <= 1);

    for (genvar g = 0; g < NCPU; g++) begin : g_per
        assert_grant_to_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
            arb_gnt[g] |-> $past(ctl_bus_req[g]));
        assert_done_after_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_done[g] |-> $past(cpu_stall[g]));
        assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_done[g] |=> !cpu_done[g]);
    end
endmodule

bind snoop_mp_system snoop_mp_checker #(
    .NCPU(NCPU), .AW(AW), .DW(DW), .NL(NL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .arb_gnt(arb_gnt), .ctl_bus_req(ctl_bus_req),
    .flush_en_v(flush_en_v), .bus_wb(bus_wb), .cpu_done(cpu_done),
    .cpu_stall(cpu_stall), .dbg_st_all(dbg_st_all), .dbg_tag_all(dbg_tag_all),
    .dbg_data_all(dbg_data_all), .mem_image(mem_image)
);

// File: tb/tb_snoop_mp_system.sv
// Self-checking bench: a vector walk of single operations, then reset and
// concurrent-store checks.
module tb_snoop_mp_system;
    localparam int NCPU = 3;
    localparam int AW   = 6;
    localparam int DW   = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCPU-1:0]     cpu_req = '0;
    logic [NCPU-1:0]     cpu_we = '0;
    logic [NCPU*AW-1:0]  cpu_addr = '0;
    logic [NCPU*DW-1:0]  cpu_wdata = '0;
    logic [NCPU*DW-1:0]  cpu_rdata;
    logic [NCPU-1:0]     cpu_done;
    logic [NCPU-1:0]     cpu_stall;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    snoop_mp_system dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_stall(cpu_stall)
    );

    // Fields: cpu[25:24] we[23] addr[22:17] wdata[16:9] exp[8:1] hit[0]
    localparam int NV = 16;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 1'b0, 6'h05, 8'h00, 8'h10, 1'b0},  // R1 R3 first load miss
        {2'd0, 1'b0, 6'h05, 8'h00, 8'h10, 1'b1},  // R2 load hit
        {2'd1, 1'b0, 6'h05, 8'h00, 8'h10, 1'b0},  // R3 second sharer
        {2'd0, 1'b1, 6'h05, 8'hA1, 8'h00, 1'b0},  // R7 store to Shared
        {2'd0, 1'b1, 6'h05, 8'hA2, 8'h00, 1'b1},  // R6 store hit Modified
        {2'd1, 1'b0, 6'h05, 8'h00, 8'hA2, 1'b0},  // R4 R7 invalidated reader
        {2'd0, 1'b0, 6'h05, 8'h00, 8'hA2, 1'b1},  // R5 owner now Shared
        {2'd0, 1'b1, 6'h05, 8'hA3, 8'h00, 1'b0},  // R5 store needs bus
        {2'd2, 1'b0, 6'h09, 8'h00, 8'h1C, 1'b0},  // R3
        {2'd2, 1'b1, 6'h09, 8'h5B, 8'h00, 1'b0},  // R7
        {2'd2, 1'b0, 6'h0D, 8'h00, 8'h28, 1'b0},  // R8 evicts dirty 0x09
        {2'd1, 1'b0, 6'h09, 8'h00, 8'h5B, 1'b0},  // R8 written-back value
        {2'd2, 1'b0, 6'h09, 8'h00, 8'h5B, 1'b0},  // R8 refetch
        {2'd1, 1'b0, 6'h05, 8'h00, 8'hA3, 1'b0},  // R4 flush from cpu0
        {2'd2, 1'b1, 6'h0D, 8'h77, 8'h00, 1'b0},  // R7
        {2'd0, 1'b0, 6'h0D, 8'h00, 8'h77, 1'b0}   // R3 R4
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One operation on one processor; returns data, latency and early stall.
    task automatic do_op(input int c, input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                         output int lat, output logic st);
        @(negedge clk);
        cpu_req[c] = 1'b1;
        cpu_we[c]  = we;
        cpu_addr[c*AW +: AW]  = a;
        cpu_wdata[c*DW +: DW] = wd;
        @(negedge clk);
        cpu_req[c] = 1'b0;
        st  = cpu_stall[c];
        lat = 1;
        while (!cpu_done[c] && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 300) check(1'b0, "R12 timeout", lat, 0);
        rd = cpu_rdata[c*DW +: DW];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int            lat;
        logic          st;
        int            t_done [NCPU];
        int            cyc;

        do_reset();
        // R1: idle after reset.
        check(cpu_stall == '0, "R1 stall", cpu_stall, 0);
        check(cpu_done == '0, "R1 done", cpu_done, 0);
        do_op(1, 1'b0, 6'h3F, 8'h00, rd, lat, st);
        check(rd == 8'hBE, "R1 init value", rd, 8'hBE);

        do_reset();
        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            e = VEC[v];
            do_op(int'(e[25:24]), e[23], e[22:17], e[16:9], rd, lat, st);
            check(st == 1'b1, "R12 stall", st, 1);
            if (!e[23]) check(rd == e[8:1], "R3 load value", rd, e[8:1]);
            if (e[0]) check(lat == 2, "R2 R6 hit latency", lat, 2);
            else      check(lat > 2, "R5 R7 miss latency", lat, 3);
        end

        // R9: simultaneous stores after reset resolve in processor order.
        do_reset();
        @(negedge clk);
        for (int c = 0; c < NCPU; c++) begin
            cpu_req[c] = 1'b1;
            cpu_we[c]  = 1'b1;
            cpu_addr[c*AW +: AW]  = 6'h30;
            cpu_wdata[c*DW +: DW] = DW'(8'hC0 + c);
            t_done[c] = -1;
        end
        @(negedge clk);
        cpu_req = '0;
        cyc = 1;
        while ((t_done[0] < 0 || t_done[1] < 0 || t_done[2] < 0) && cyc < 500) begin
            for (int c = 0; c < NCPU; c++) if (cpu_done[c]) t_done[c] = cyc;
            @(negedge clk);
            cyc++;
        end
        check(t_done[0] > 0 && t_done[0] < t_done[1], "R9 order 0 before 1", t_done[0], t_done[1]);
        check(t_done[1] < t_done[2], "R9 order 1 before 2", t_done[1], t_done[2]);
        for (int c = 0; c < NCPU; c++) begin
            do_op(c, 1'b0, 6'h30, 8'h00, rd, lat, st);
            check(rd == 8'hC2, "R9 final value", rd, 8'hC2);
        end

        summary();
        $finish;
    end
endmodule